// File: doc/BRIEF.md
# Color Lookup Palette with Byte-Wide Host Port

This block holds a 256-entry table of red, green and blue bytes. It turns an 8-bit pixel index into a color. A host reaches the table through a small byte-wide register port. It loads a start entry into a write pointer and then sends component bytes to a data register. The block steers each byte to red, green or blue in turn. After each blue byte the pointer moves to the next entry, so a run of consecutive entries needs only one pointer write. Readback works the same way through a separate read pointer. The write pointer and the read pointer share one red/green/blue position counter.

On the pixel side, the incoming index is ANDed with a programmable 8-bit read mask before the lookup. The selected color appears one cycle later. A control bit chooses between full 8-bit components and 6-bit components. In 6-bit mode the two low bits of each output component are forced to zero.

The table has a single port. A pixel lookup always wins that port. A host access that arrives while a pixel is being looked up is parked in a small two-state arbiter. It runs in the next cycle with no pixel lookup. Each host access ends with a one-cycle done pulse that also carries any read data. The arbiter has two states. In `ARB_IDLE` (nothing parked), a request with no pixel runs at once and the state stays `ARB_IDLE`. A request that meets a pixel is captured, and the arbiter moves along the transition *defer* to `ARB_HOLD`. In `ARB_HOLD` the arbiter stays put while pixels keep coming. It takes the transition *drain* back to `ARB_IDLE` in the first cycle with no pixel, and runs the parked access in that cycle.

Top module: `clut_palette`

## Requirements
- R1: After reset, `out_valid` and `host_done` are low. The read mask reads back 0xFF, the control register reads 0 (6-bit mode), both pointers read 0, and every palette entry holds zero in all three components.
- R2: A host write with `host_sel`=0 loads the write pointer. The next three writes with `host_sel`=1 store red, green and blue, in that order, into the entry the pointer names.
- R3: After the blue byte of a write triplet, the write pointer increments by one, wrapping from 255 to 0, so later triplets fill the following entries.
- R4: A host write with `host_sel`=2 loads the read pointer. The next three reads with `host_sel`=1 return red, green and blue of that entry, and the read pointer increments by one (wrapping 255 to 0) after the blue byte.
- R5: A write to either pointer (`host_sel` 0 or 2) returns the shared component position to red, even when a triplet was left unfinished.
- R6: The read mask (`host_sel`=3, 8 bits) is ANDed with `pix_index` before the lookup, so only the entry at `pix_index & mask` is read.
- R7: `out_valid` is high in exactly the cycles that follow a cycle with `pix_valid` high. The output color is the one looked up in that earlier cycle.
- R8: Bit 0 of the control register (`host_sel`=4) selects 8-bit output when 1 and 6-bit output when 0. In 6-bit mode each output component is the stored byte with its two low bits forced to zero.
- R9: A host access never runs in a cycle with `pix_valid` high. A deferred access runs in the first later cycle with `pix_valid` low.
- R10: `host_done` pulses for one cycle, the cycle after an access runs. For a read, `host_rdata` then holds the result. Reads of selects 0, 2, 3 and 4 return the write pointer, read pointer, mask and control value.
- R11: Selects 5 to 7 are unused. Writes to them change no state, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | One-cycle host access request; the next request waits for `host_done` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 3 | Register select: 0 write pointer, 1 data, 2 read pointer, 3 mask, 4 control |
| host_wdata | input | 8 | Write byte |
| host_done | output | 1 | Access completed (one-cycle pulse) |
| host_rdata | output | 8 | Read result, valid with `host_done` |
| pix_valid | input | 1 | Pixel lookup request |
| pix_index | input | 8 | Pixel palette index |
| out_valid | output | 1 | Output color valid |
| out_red | output | 8 | Red component |
| out_green | output | 8 | Green component |
| out_blue | output | 8 | Blue component |

## Verification
The lookup is tried with a narrow mask, so that two distinct indices fold onto one entry. It is also tried with a full mask in both output widths, which separates masking errors from truncation errors. The host path is tried in three ways:
- Contiguous triplet streams across the 255-to-0 boundary expose pointer step and wrap faults.
- Abandoned half-triplets followed by a pointer write show whether the component position is cleared.
- Requests timed to land on active pixel cycles separate a correct deferral from an access that runs early or is lost.

A long stretch of mixed random pixel and host traffic is compared every cycle against a behavioural model. It catches ordering faults that the directed cases do not reach.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [2:0] SEL_WPTR = 3'd0;
    localparam logic [2:0] SEL_DATA = 3'd1;
    localparam logic [2:0] SEL_RPTR = 3'd2;
    localparam logic [2:0] SEL_MASK = 3'd3;
    localparam logic [2:0] SEL_CTRL = 3'd4;

    typedef enum logic [1:0] {
        COMP_RED   = 2'd0,
        COMP_GREEN = 2'd1,
        COMP_BLUE  = 2'd2
    } comp_e;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic              we;
        logic [2:0]        sel;
        logic [BYTE_W-1:0] wdata;
    } host_op_t;

    function automatic comp_e comp_next(input comp_e c);
        unique case (c)
            COMP_RED:   return COMP_GREEN;
            COMP_GREEN: return COMP_BLUE;
            default:    return COMP_RED;
        endcase
    endfunction

endpackage

// File: rtl/clut_arb.sv
module clut_arb
    import clut_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     host_req,
    input  host_op_t host_op,
    input  logic     pix_valid,
    output logic     exec_go,
    output host_op_t exec_op
);

    arb_state_e state_q, state_d;
    host_op_t   held_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // parked request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (state_q == ARB_IDLE && host_req && pix_valid) begin
            held_q <= host_op;
        end
    end

    // transitions: defer (IDLE->HOLD), drain (HOLD->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: if (host_req && pix_valid) state_d = ARB_HOLD;
            ARB_HOLD: if (!pix_valid)            state_d = ARB_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        exec_go = 1'b0;
        exec_op = host_op;
        unique case (state_q)
            ARB_IDLE: begin
                exec_go = host_req && !pix_valid;
                exec_op = host_op;
            end
            ARB_HOLD: begin
                exec_go = !pix_valid;
                exec_op = held_q;
            end
        endcase
    end

    p_pixel_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> !exec_go);

    p_defer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && host_req && pix_valid) |=> (state_q == ARB_HOLD));

    p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_HOLD && !pix_valid) |-> exec_go);

endmodule

// File: rtl/clut_hostregs.sv
module clut_hostregs
    import clut_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_go,
    input  host_op_t          exec_op,
    input  logic [BYTE_W-1:0] mem_rd_byte,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output comp_e             mem_wcomp,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [AW-1:0]     mem_raddr,
    output comp_e             mem_rcomp,
    output logic [BYTE_W-1:0] pix_mask,
    output logic              mode8,
    output logic              host_done,
    output logic [BYTE_W-1:0] host_rdata
);

    logic [AW-1:0]     wptr_q, rptr_q;
    comp_e             pos_q;
    logic [BYTE_W-1:0] mask_q;
    logic              mode8_q;
    logic              done_q;
    logic [BYTE_W-1:0] rdata_q;

    assign mem_we    = exec_go && exec_op.we && (exec_op.sel == SEL_DATA);
    assign mem_waddr = wptr_q;
    assign mem_wcomp = pos_q;
    assign mem_wdata = exec_op.wdata;
    assign mem_raddr = rptr_q;
    assign mem_rcomp = pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            pos_q   <= COMP_RED;
            mask_q  <= '1;
            mode8_q <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= exec_go;
            if (exec_go) begin
                case (exec_op.sel)
                    SEL_WPTR: begin
                        if (exec_op.we) begin
                            wptr_q <= exec_op.wdata[AW-1:0];
                            pos_q  <= COMP_RED;
                        end else begin
                            rdata_q <= BYTE_W'(wptr_q);
                        end
                    end
                    SEL_RPTR: begin
                        if (exec_op.we) begin
                            rptr_q <= exec_op.wdata[AW-1:0];
                            pos_q  <= COMP_RED;
                        end else begin
                            rdata_q <= BYTE_W'(rptr_q);
                        end
                    end
                    SEL_DATA: begin
                        pos_q <= comp_next(pos_q);
                        if (!exec_op.we) rdata_q <= mem_rd_byte;
                        if (pos_q == COMP_BLUE) begin
                            if (exec_op.we) wptr_q <= wptr_q + 1'b1;
                            else            rptr_q <= rptr_q + 1'b1;
                        end
                    end
                    SEL_MASK: begin
                        if (exec_op.we) mask_q  <= exec_op.wdata;
                        else            rdata_q <= mask_q;
                    end
                    SEL_CTRL: begin
                        if (exec_op.we) mode8_q <= exec_op.wdata[0];
                        else            rdata_q <= {{(BYTE_W-1){1'b0}}, mode8_q};
                    end
                    default: begin
                        if (!exec_op.we) rdata_q <= '0;
                    end
                endcase
            end
        end
    end

    assign pix_mask   = mask_q;
    assign mode8      = mode8_q;
    assign host_done  = done_q;
    assign host_rdata = rdata_q;

    p_pos_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_go && exec_op.we && (exec_op.sel == SEL_WPTR || exec_op.sel == SEL_RPTR))
        |=> (pos_q == COMP_RED));

    p_wptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_go && exec_op.we && exec_op.sel == SEL_DATA && pos_q == COMP_BLUE)
        |=> (wptr_q == $past(wptr_q) + 1'b1));

    p_rptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_go && !exec_op.we && exec_op.sel == SEL_DATA && pos_q == COMP_BLUE)
        |=> (rptr_q == $past(rptr_q) + 1'b1));

    p_pos_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q != 2'd3);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exec_go |=> host_done);

    p_unused_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_go && exec_op.sel > SEL_CTRL)
        |=> ($stable(mask_q) && $stable(wptr_q) && $stable(rptr_q) && $stable(mode8_q)));

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  comp_e         wr_comp,
    input  logic [CW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    input  comp_e         rd_comp,
    output logic [CW-1:0] rd_byte,
    input  logic          pix_valid,
    input  logic [AW-1:0] pix_addr,
    input  logic          mode8,
    output logic          out_valid,
    output logic [CW-1:0] out_red,
    output logic [CW-1:0] out_green,
    output logic [CW-1:0] out_blue
);

    localparam int unsigned DEPTH  = 1 << AW;
    localparam int unsigned NCOMP  = 3;
    localparam int unsigned DROP   = CW - 6;

    logic [CW-1:0] host_bytes [NCOMP];
    logic [CW-1:0] pix_bytes  [NCOMP];
    logic [CW-1:0] color_q    [NCOMP];
    logic          valid_q;

    for (genvar g = 0; g < NCOMP; g++) begin : g_plane
        logic [CW-1:0] plane [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) plane[i] <= '0;
            end else if (wr_en && wr_comp == comp_e'(g)) begin
                plane[wr_addr] <= wr_data;
            end
        end

        assign host_bytes[g] = plane[rd_addr];
        assign pix_bytes[g]  = plane[pix_addr];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                color_q[g] <= '0;
            end else if (pix_valid) begin
                color_q[g] <= mode8 ? pix_bytes[g]
                                    : {pix_bytes[g][CW-1:DROP], {DROP{1'b0}}};
            end
        end
    end

    always_comb begin
        unique case (rd_comp)
            COMP_GREEN: rd_byte = host_bytes[1];
            COMP_BLUE:  rd_byte = host_bytes[2];
            default:    rd_byte = host_bytes[0];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= pix_valid;
    end

    assign out_valid = valid_q;
    assign out_red   = color_q[0];
    assign out_green = color_q[1];
    assign out_blue  = color_q[2];

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    p_six_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !mode8) |=>
        (out_red[DROP-1:0] == '0 && out_green[DROP-1:0] == '0 && out_blue[DROP-1:0] == '0));

endmodule

// File: rtl/clut_palette.sv
module clut_palette
    import clut_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [2:0]        host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic              host_done,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              pix_valid,
    input  logic [AW-1:0]     pix_index,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_red,
    output logic [BYTE_W-1:0] out_green,
    output logic [BYTE_W-1:0] out_blue
);

    host_op_t          live_op, exec_op;
    logic              exec_go;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr, mem_raddr, pix_addr;
    comp_e             mem_wcomp, mem_rcomp;
    logic [BYTE_W-1:0] mem_wdata, mem_rd_byte, pix_mask;
    logic              mode8;

    assign live_op  = '{we: host_we, sel: host_sel, wdata: host_wdata};
    assign pix_addr = pix_index & pix_mask[AW-1:0];

    clut_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_req  (host_req),
        .host_op   (live_op),
        .pix_valid (pix_valid),
        .exec_go   (exec_go),
        .exec_op   (exec_op)
    );

    clut_hostregs #(.AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .exec_go     (exec_go),
        .exec_op     (exec_op),
        .mem_rd_byte (mem_rd_byte),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_wcomp   (mem_wcomp),
        .mem_wdata   (mem_wdata),
        .mem_raddr   (mem_raddr),
        .mem_rcomp   (mem_rcomp),
        .pix_mask    (pix_mask),
        .mode8       (mode8),
        .host_done   (host_done),
        .host_rdata  (host_rdata)
    );

    clut_store #(.AW(AW), .CW(BYTE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mem_we),
        .wr_addr   (mem_waddr),
        .wr_comp   (mem_wcomp),
        .wr_data   (mem_wdata),
        .rd_addr   (mem_raddr),
        .rd_comp   (mem_rcomp),
        .rd_byte   (mem_rd_byte),
        .pix_valid (pix_valid),
        .pix_addr  (pix_addr),
        .mode8     (mode8),
        .out_valid (out_valid),
        .out_red   (out_red),
        .out_green (out_green),
        .out_blue  (out_blue)
    );

    p_host_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !pix_valid);

endmodule

// File: tb/sim_clut_palette.sv
module sim_clut_palette;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_req = 1'b0;
    logic       host_we = 1'b0;
    logic [2:0] host_sel = '0;
    logic [7:0] host_wdata = '0;
    logic       host_done;
    logic [7:0] host_rdata;
    logic       pix_valid = 1'b0;
    logic [7:0] pix_index = '0;
    logic       out_valid;
    logic [7:0] out_red, out_green, out_blue;

    always #4 clk = ~clk;

    clut_palette u0 (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_done(host_done), .host_rdata(host_rdata),
        .pix_valid(pix_valid), .pix_index(pix_index),
        .out_valid(out_valid), .out_red(out_red), .out_green(out_green), .out_blue(out_blue)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference model
    int    m_mem [256][3];
    int    m_wp, m_rp, m_pos, m_mask, m_mode8;
    bit    m_pend, p_we;
    int    p_sel, p_data;
    bit    e_done, e_rdchk, e_ov;
    int    e_rdata, e_r, e_g, e_b;
    string e_dtag, e_ctag;

    task automatic model_reset();
        for (int i = 0; i < 256; i++) for (int c = 0; c < 3; c++) m_mem[i][c] = 0;
        m_wp = 0; m_rp = 0; m_pos = 0; m_mask = 255; m_mode8 = 0;
        m_pend = 0; e_done = 0; e_rdchk = 0; e_ov = 0;
    endtask

    function automatic int shape(input int v);
        return m_mode8 ? v : (v & 252);
    endfunction

    task automatic run_op(input bit we, input int sel, input int d);
        e_done = 1; e_rdchk = !we; e_dtag = "R10";
        case (sel)
            0: if (we) begin m_wp = d; m_pos = 0; end else e_rdata = m_wp;
            2: if (we) begin m_rp = d; m_pos = 0; end else e_rdata = m_rp;
            1: begin
                if (we) m_mem[m_wp][m_pos] = d;
                else begin e_rdata = m_mem[m_rp][m_pos]; e_dtag = "R4"; end
                if (m_pos == 2) begin
                    m_pos = 0;
                    if (we) m_wp = (m_wp + 1) % 256; else m_rp = (m_rp + 1) % 256;
                end else m_pos++;
            end
            3: if (we) m_mask = d; else e_rdata = m_mask;
            4: if (we) m_mode8 = d & 1; else e_rdata = m_mode8;
            default: begin e_rdata = 0; e_dtag = "R11"; end
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            e_done = 0; e_rdchk = 0;
            e_ov = pix_valid;
            if (pix_valid) begin
                int idx;
                idx = pix_index & m_mask;
                e_r = shape(m_mem[idx][0]);
                e_g = shape(m_mem[idx][1]);
                e_b = shape(m_mem[idx][2]);
                e_ctag = m_mode8 ? "R6" : "R8";
            end
            if (m_pend) begin
                if (!pix_valid) begin run_op(p_we, p_sel, p_data); m_pend = 0; end
            end else if (host_req) begin
                if (pix_valid) begin
                    m_pend = 1; p_we = host_we; p_sel = host_sel; p_data = host_wdata;
                end else run_op(host_we, host_sel, host_wdata);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        if (rst_n) begin
            check(out_valid == e_ov, "R7", "out_valid", out_valid, e_ov);
            if (e_ov) begin
                check(out_red   == e_r[7:0], e_ctag, "red",   out_red,   e_r);
                check(out_green == e_g[7:0], e_ctag, "green", out_green, e_g);
                check(out_blue  == e_b[7:0], e_ctag, "blue",  out_blue,  e_b);
            end
            check(host_done == e_done, "R9", "host_done", host_done, e_done);
            if (e_done && e_rdchk)
                check(host_rdata == e_rdata[7:0], e_dtag, "host_rdata", host_rdata, e_rdata);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic host_op(input bit we, input int sel, input int d, output int rd);
        host_req = 1; host_we = we; host_sel = sel[2:0]; host_wdata = d[7:0];
        tick();
        host_req = 0;
        for (int i = 0; i < 32 && !host_done; i++) tick();
        rd = host_rdata;
        tick();
    endtask

    task automatic hw(input int sel, input int d);
        int unused;
        host_op(1, sel, d, unused);
    endtask

    task automatic hr(input int sel, input int exp, input string tag);
        int v;
        host_op(0, sel, 0, v);
        check(v == exp, tag, "register read", v, exp);
    endtask

    task automatic pix(input int idx, input int er, input int eg, input int eb, input string tag);
        pix_valid = 1; pix_index = idx[7:0];
        tick();
        pix_valid = 0;
        check(out_valid == 1'b1, "R7", "lookup valid", out_valid, 1);
        check(out_red == er[7:0] && out_green == eg[7:0] && out_blue == eb[7:0], tag, "lookup rgb",
              {out_red, out_green, out_blue}, (er << 16) | (eg << 8) | eb);
        tick();
        check(out_valid == 1'b0, "R7", "valid drops", out_valid, 0);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL R9 watchdog: actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R1 reset state
        check(out_valid == 0 && host_done == 0, "R1", "outputs after reset", {out_valid, host_done}, 0);
        hr(3, 8'hFF, "R1");
        hr(4, 0, "R1");
        hr(0, 0, "R1");
        pix(7, 0, 0, 0, "R1");

        // R2 R3 contiguous writes, R4 readback
        hw(0, 10);
        hw(1, 8'h12); hw(1, 8'h34); hw(1, 8'h56);
        hw(1, 8'h9A); hw(1, 8'hBC); hw(1, 8'hDE);
        hr(0, 12, "R3");
        hw(2, 10);
        hr(1, 8'h12, "R4"); hr(1, 8'h34, "R4"); hr(1, 8'h56, "R4");
        hr(1, 8'h9A, "R2"); hr(1, 8'hBC, "R2"); hr(1, 8'hDE, "R2");
        hr(2, 12, "R4");

        // R3 wrap 255 -> 0
        hw(0, 255);
        hw(1, 1); hw(1, 2); hw(1, 3);
        hw(1, 4); hw(1, 5); hw(1, 6);
        hr(0, 1, "R3");
        hw(2, 255);
        hr(1, 1, "R3"); hr(1, 2, "R3"); hr(1, 3, "R3");
        hr(1, 4, "R3"); hr(1, 5, "R3"); hr(1, 6, "R3");

        // R5 position cleared by pointer writes
        hw(0, 20); hw(1, 8'hAA); hw(1, 8'hBB);
        hw(0, 20); hw(1, 8'h11); hw(1, 8'h22); hw(1, 8'h33);
        hw(2, 20);
        hr(1, 8'h11, "R5"); hr(1, 8'h22, "R5"); hr(1, 8'h33, "R5");
        hw(2, 10); hr(1, 8'h12, "R5");
        hw(2, 11); hr(1, 8'h9A, "R5");

        // R6 masking, R8 6-bit default
        hw(3, 8'h0F);
        pix(8'h1B, 8'h98, 8'hBC, 8'hDC, "R6");
        pix(8'hF4, 0, 0, 0, "R6");
        // R8 8-bit mode
        hw(4, 1);
        pix(8'h0B, 8'h9A, 8'hBC, 8'hDE, "R8");
        hw(3, 8'hFF);
        pix(8'hFF, 1, 2, 3, "R8");
        hw(4, 0);
        pix(8'hFF, 0, 0, 0, "R8");

        // R11 unused selects
        hw(5, 8'h77); hw(7, 8'h00);
        hr(3, 8'hFF, "R11");
        hr(4, 0, "R11");
        hr(6, 0, "R11");

        // R9 pixel priority and deferral
        host_req = 1; host_we = 1; host_sel = 3'd3; host_wdata = 8'h3C;
        pix_valid = 1; pix_index = 8'h0B;
        tick();
        host_req = 0;
        check(host_done == 0, "R9", "no completion during pixel", host_done, 0);
        tick();
        check(host_done == 0, "R9", "still deferred", host_done, 0);
        tick();
        check(host_done == 0, "R9", "still deferred", host_done, 0);
        pix_valid = 0;
        tick();
        check(host_done == 1, "R9", "completes in free cycle", host_done, 1);
        tick();
        check(host_done == 0, "R10", "done is one pulse", host_done, 0);
        hr(3, 8'h3C, "R9");

        // mixed traffic checked every cycle by the model
        begin
            bit outst = 0;
            for (int n = 0; n < 3000; n++) begin
                pix_valid = ($urandom % 3) != 0;
                pix_index = 8'($urandom);
                if (!outst && ($urandom % 4) == 0) begin
                    int s;
                    s = $urandom % 8;
                    host_req = 1; host_we = $urandom % 2;
                    host_sel = s[2:0];
                    host_wdata = (s == 0 || s == 2) ? 8'($urandom % 8) : 8'($urandom);
                    outst = 1;
                end
                tick();
                host_req = 0;
                if (host_done) outst = 0;
            end
            pix_valid = 0;
            repeat (4) tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule